// File: doc/BRIEF.md
# SV39 Translation Lookaside Buffer

This block is a small, fully associative cache that holds recently completed SV39 address translations. A lookup presents a 39-bit virtual address, the address space identifier of the running context and the kind of access. In the same cycle the block answers with exactly one of three outcomes. A hit delivers the physical address. A miss tells the core that a hardware page table walk is needed. A permission fault reports a page fault, because a matching entry exists but does not allow the access.

When the walker finishes, it installs its result through the refill port. The result is a virtual page number, an ASID, a physical page number, a page size (4 KB, 2 MB or 1 GB) and the leaf permission flags. An invalidate port follows fence semantics. It can drop every entry, or only the entries that map one address, or only the non-global entries of one address space, or the entries that meet both conditions. This keeps stale translations from being returned after software edits the page tables.

The store has eight entries. An empty slot is always filled first. When every slot is in use, a round-robin pointer picks the victim.

Top module: `vmTlb`

## Requirements
- R1: After reset every entry is empty, so every lookup reports a miss.
- R2: A hit is reported in the same cycle as the lookup. Its physical address is the entry's physical page number placed above the untranslated low bits of the virtual address: 12 bits for a 4 KB page, 21 bits for a 2 MB page and 30 bits for a 1 GB page.
- R3: While lkValid is high, exactly one of lkHit, lkMiss and lkFault is high. While lkValid is low, all three are low and lkPaddr is zero. lkPaddr is also zero whenever lkHit is low.
- R4: fillSize selects the page size: 0 is 4 KB, 1 is 2 MB, and 2 or 3 is 1 GB. A 4 KB entry compares all 27 VPN bits (virtual address bits 38:12). A 2 MB entry compares bits 38:21. A 1 GB entry compares bits 38:30.
- R5: A non-global entry matches only a lookup whose ASID equals the ASID the entry was filled with.
- R6: An entry whose global flag is set matches a lookup with any ASID.
- R7: fillFlags uses bit 0 for valid, bit 1 for read, bit 2 for write, bit 3 for execute and bit 4 for global. lkAccess uses 0 for load, 1 for store, and 2 or 3 for instruction fetch. A lookup that matches an entry reports lkFault instead of lkHit when the entry's valid flag is clear, or when the entry lacks the read, write or execute flag that the access needs.
- R8: An invalidate with neither flushUseAddr nor flushUseAsid set empties every entry.
- R9: An invalidate with only flushUseAddr set removes every entry whose page contains flushVpn, whatever its ASID and including global entries.
- R10: An invalidate with only flushUseAsid set removes the non-global entries that carry flushAsid and keeps global entries.
- R11: An invalidate with both selectors set removes only the non-global entries that carry flushAsid and also contain flushVpn.
- R12: A refill becomes visible to lookups from the cycle after it is presented. A refill presented in the same cycle as an invalidate is discarded.
- R13: A refill goes into the lowest-numbered empty slot. When no slot is empty, it goes into the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping after the last slot, only on refills that replace a used slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 39 | Lookup virtual address |
| lkAsid | input | 16 | ASID of the requesting context |
| lkAccess | input | 2 | Access kind: 0 load, 1 store, 2/3 fetch |
| lkHit | output | 1 | Translation found and permitted |
| lkMiss | output | 1 | No matching entry; a walk is needed |
| lkFault | output | 1 | Matching entry forbids the access |
| lkPaddr | output | 56 | Physical address when lkHit is high, else zero |
| fillValid | input | 1 | Refill request from the walker |
| fillVpn | input | 27 | Virtual page number of the refill |
| fillAsid | input | 16 | ASID of the refill |
| fillPpn | input | 44 | Physical page number of the refill |
| fillSize | input | 2 | Page size code of the refill |
| fillFlags | input | 5 | Leaf flags {global, execute, write, read, valid} |
| flushValid | input | 1 | Invalidate request |
| flushUseAddr | input | 1 | Restrict the invalidate to flushVpn |
| flushVpn | input | 27 | Page number selected for the invalidate |
| flushUseAsid | input | 1 | Restrict the invalidate to flushAsid |
| flushAsid | input | 16 | ASID selected for the invalidate |

## Verification
The hardest behaviour to reach from the ports is round-robin replacement that interacts with holes left by selective invalidation. The pointer moves only when all eight slots are in use, so it is reached only after a full set of refills. A later freed slot must then be taken ahead of the pointer, and the pointer must stay where it was. The stimulus first fills eight distinct pages and then overflows the store twice. It next frees one slot by address and refills twice. It then looks up all twelve pages and reads off which one was evicted. Separately, mixed page sizes and global entries are lined up so that one address-only invalidate removes a global 1 GB mapping through a page number that differs from its own in the lower VPN fields.

// File: rtl/vmTlbPkg.sv
package vmTlbPkg;
  localparam int VA_W    = 39;
  localparam int OFF_W   = 12;
  localparam int VPN_W   = 9;
  localparam int VPN_TOT = VA_W - OFF_W;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_1GX = 2'd3
  } pageSizeE;

  typedef enum logic [1:0] {
    ACC_LOAD   = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_FETCH  = 2'd2,
    ACC_FETCHX = 2'd3
  } accessE;

  typedef struct packed {
    logic g;
    logic x;
    logic w;
    logic r;
    logic v;
  } pteFlagsT;

  typedef struct packed {
    logic fillWe;
    logic flushWe;
  } ctrlStrobeT;
endpackage

// File: rtl/vmTlbCtrl.sv
module vmTlbCtrl
  import vmTlbPkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               flushValid,
  input  logic [ENTRIES-1:0] usedVec,
  output ctrlStrobeT         strobe,
  output logic [IDX_W-1:0]   fillIdx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrQ;
  logic [IDX_W-1:0] freeIdx;
  logic             anyFree;

  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!usedVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign strobe.flushWe = flushValid;
  assign strobe.fillWe  = fillValid && !flushValid;
  assign fillIdx        = anyFree ? freeIdx : rrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrQ <= '0;
    end else if (strobe.fillWe && !anyFree) begin
      rrQ <= (rrQ == LAST) ? '0 : rrQ + 1'b1;
    end
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillWe && !(&usedVec)) |-> !usedVec[fillIdx]); // R13
  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillWe && (&usedVec)) |=>
      (rrQ == (($past(rrQ) == LAST) ? '0 : $past(rrQ) + 1'b1))); // R13
endmodule

// File: rtl/vmTlbDatapath.sv
module vmTlbDatapath
  import vmTlbPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 16,
  parameter int PPN_W   = 44,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [VPN_TOT-1:0] fillVpn,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [PPN_W-1:0]   fillPpn,
  input  pageSizeE           fillSize,
  input  pteFlagsT           fillFlags,
  input  logic               flushUseAddr,
  input  logic [VPN_TOT-1:0] flushVpn,
  input  logic               flushUseAsid,
  input  logic [ASID_W-1:0]  flushAsid,
  input  logic               lkValid,
  input  logic [VA_W-1:0]    lkVaddr,
  input  logic [ASID_W-1:0]  lkAsid,
  input  accessE             lkAccess,
  output logic [ENTRIES-1:0] usedVec,
  output logic               lkHit,
  output logic               lkMiss,
  output logic               lkFault,
  output logic [PA_W-1:0]    lkPaddr
);
  localparam int LO_W  = OFF_W + VPN_W;
  localparam int MID_W = OFF_W + 2 * VPN_W;

  logic [ENTRIES-1:0] usedQ;
  logic [VPN_TOT-1:0] vpnQ   [ENTRIES];
  logic [ASID_W-1:0]  asidQ  [ENTRIES];
  logic [PPN_W-1:0]   ppnQ   [ENTRIES];
  pageSizeE           sizeQ  [ENTRIES];
  pteFlagsT           flagsQ [ENTRIES];

  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] flushHit;
  logic [IDX_W-1:0]   selIdx;
  logic               anyMatch;
  logic               allowed;
  pteFlagsT           selFlags;
  logic [PPN_W-1:0]   selPpn;
  logic [PA_W-1:0]    pagePa;
  logic [VPN_TOT-1:0] lkVpn;

  assign lkVpn   = lkVaddr[VA_W-1:OFF_W];
  assign usedVec = usedQ;

  function automatic logic pageMatch(input logic [VPN_TOT-1:0] a,
                                     input logic [VPN_TOT-1:0] b,
                                     input pageSizeE sz);
    logic top, mid, low;
    top = a[3*VPN_W-1:2*VPN_W] == b[3*VPN_W-1:2*VPN_W];
    mid = a[2*VPN_W-1:VPN_W] == b[2*VPN_W-1:VPN_W];
    low = a[VPN_W-1:0] == b[VPN_W-1:0];
    case (sz)
      PG_4K:   return top && mid && low;
      PG_2M:   return top && mid;
      default: return top;
    endcase
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    assign lkMatch[i] = usedQ[i] && pageMatch(vpnQ[i], lkVpn, sizeQ[i]) &&
                        (flagsQ[i].g || asidQ[i] == lkAsid);
    assign flushHit[i] = usedQ[i] &&
                         (!flushUseAddr || pageMatch(vpnQ[i], flushVpn, sizeQ[i])) &&
                         (!flushUseAsid || (!flagsQ[i].g && asidQ[i] == flushAsid));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedQ <= '0;
    end else if (strobe.flushWe) begin
      usedQ <= usedQ & ~flushHit;
    end else if (strobe.fillWe) begin
      usedQ[fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWe) begin
      vpnQ[fillIdx]   <= fillVpn;
      asidQ[fillIdx]  <= fillAsid;
      ppnQ[fillIdx]   <= fillPpn;
      sizeQ[fillIdx]  <= fillSize;
      flagsQ[fillIdx] <= fillFlags;
    end
  end

  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) selIdx = IDX_W'(i);
    end
  end
  assign anyMatch = |lkMatch;

  always_comb begin
    selFlags = flagsQ[selIdx];
    selPpn   = ppnQ[selIdx];
    case (lkAccess)
      ACC_LOAD:  allowed = selFlags.r;
      ACC_STORE: allowed = selFlags.w;
      default:   allowed = selFlags.x;
    endcase
    allowed = allowed && selFlags.v;
    case (sizeQ[selIdx])
      PG_4K:   pagePa = {selPpn, lkVaddr[OFF_W-1:0]};
      PG_2M:   pagePa = {selPpn[PPN_W-1:VPN_W], lkVaddr[LO_W-1:0]};
      default: pagePa = {selPpn[PPN_W-1:2*VPN_W], lkVaddr[MID_W-1:0]};
    endcase
  end

  assign lkHit   = lkValid && anyMatch && allowed;
  assign lkFault = lkValid && anyMatch && !allowed;
  assign lkMiss  = lkValid && !anyMatch;
  assign lkPaddr = lkHit ? pagePa : '0;

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillWe |=> usedQ[$past(fillIdx)]); // R12
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushWe |=> ((usedQ & $past(flushHit)) == '0)); // R9
endmodule

// File: rtl/vmTlb.sv
module vmTlb
  import vmTlbPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 16,
  parameter int PPN_W   = 44,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic [VA_W-1:0]    lkVaddr,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic [1:0]         lkAccess,
  output logic               lkHit,
  output logic               lkMiss,
  output logic               lkFault,
  output logic [PA_W-1:0]    lkPaddr,
  input  logic               fillValid,
  input  logic [VPN_TOT-1:0] fillVpn,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [1:0]         fillSize,
  input  logic [4:0]         fillFlags,
  input  logic               flushValid,
  input  logic               flushUseAddr,
  input  logic [VPN_TOT-1:0] flushVpn,
  input  logic               flushUseAsid,
  input  logic [ASID_W-1:0]  flushAsid
);
  localparam int IDX_W = $clog2(ENTRIES);

  ctrlStrobeT         strobe;
  logic [IDX_W-1:0]   fillIdx;
  logic [ENTRIES-1:0] usedVec;

  vmTlbCtrl #(.ENTRIES(ENTRIES)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fillValid (fillValid),
    .flushValid(flushValid),
    .usedVec   (usedVec),
    .strobe    (strobe),
    .fillIdx   (fillIdx)
  );

  vmTlbDatapath #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .PPN_W(PPN_W)) dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .fillIdx     (fillIdx),
    .fillVpn     (fillVpn),
    .fillAsid    (fillAsid),
    .fillPpn     (fillPpn),
    .fillSize    (pageSizeE'(fillSize)),
    .fillFlags   (pteFlagsT'(fillFlags)),
    .flushUseAddr(flushUseAddr),
    .flushVpn    (flushVpn),
    .flushUseAsid(flushUseAsid),
    .flushAsid   (flushAsid),
    .lkValid     (lkValid),
    .lkVaddr     (lkVaddr),
    .lkAsid      (lkAsid),
    .lkAccess    (accessE'(lkAccess)),
    .usedVec     (usedVec),
    .lkHit       (lkHit),
    .lkMiss      (lkMiss),
    .lkFault     (lkFault),
    .lkPaddr     (lkPaddr)
  );

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> ($countones({lkHit, lkMiss, lkFault}) == 1)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!lkHit && !lkMiss && !lkFault && lkPaddr == '0)); // R3
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && !flushUseAddr && !flushUseAsid) |=> (usedVec == '0)); // R8
  AST_FILL_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && flushValid) |=>
      ($countones(usedVec) <= $countones($past(usedVec)))); // R12
endmodule

// File: tb/vmTlb_test.sv
module vmTlb_test;
  localparam int NE = 8;
  localparam logic [4:0] FL_V = 5'd1, FL_R = 5'd2, FL_W = 5'd4, FL_X = 5'd8, FL_G = 5'd16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lkValid;
  logic [38:0] lkVaddr;
  logic [15:0] lkAsid;
  logic [1:0]  lkAccess;
  logic        lkHit, lkMiss, lkFault;
  logic [55:0] lkPaddr;
  logic        fillValid;
  logic [26:0] fillVpn;
  logic [15:0] fillAsid;
  logic [43:0] fillPpn;
  logic [1:0]  fillSize;
  logic [4:0]  fillFlags;
  logic        flushValid, flushUseAddr, flushUseAsid;
  logic [26:0] flushVpn;
  logic [15:0] flushAsid;

  int vectors = 0;
  int errors  = 0;

  bit          mUsed [NE];
  logic [63:0] mVa   [NE];
  logic [15:0] mAsid [NE];
  logic [63:0] mPpn  [NE];
  int          mLvl  [NE];
  logic [4:0]  mFl   [NE];
  int          mRr = 0;

  vmTlb #(.ENTRIES(NE)) uut (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkAsid(lkAsid), .lkAccess(lkAccess),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkFault(lkFault), .lkPaddr(lkPaddr),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillAsid(fillAsid), .fillPpn(fillPpn),
    .fillSize(fillSize), .fillFlags(fillFlags),
    .flushValid(flushValid), .flushUseAddr(flushUseAddr), .flushVpn(flushVpn),
    .flushUseAsid(flushUseAsid), .flushAsid(flushAsid)
  );

  always #5 clk = ~clk;

  function automatic logic [38:0] mkVa(int v2, int v1, int v0, int off);
    return {9'(v2), 9'(v1), 9'(v0), 12'(off)};
  endfunction

  function automatic int shiftOf(int lvl);
    return 12 + 9 * lvl;
  endfunction

  function automatic bit sameRegion(logic [63:0] a, logic [63:0] b, int lvl);
    return (a >> shiftOf(lvl)) == (b >> shiftOf(lvl));
  endfunction

  task automatic clearInputs();
    lkValid = 0; lkVaddr = '0; lkAsid = '0; lkAccess = '0;
    fillValid = 0; fillVpn = '0; fillAsid = '0; fillPpn = '0; fillSize = '0; fillFlags = '0;
    flushValid = 0; flushUseAddr = 0; flushVpn = '0; flushUseAsid = 0; flushAsid = '0;
  endtask

  task automatic checkNow(string tag);
    bit eHit = 0, eMiss = 0, eFault = 0;
    logic [63:0] ePa = '0;
    int found = -1;
    if (lkValid) begin
      for (int i = 0; i < NE; i++) begin
        if (found < 0 && mUsed[i] && sameRegion(mVa[i], 64'(lkVaddr), mLvl[i]) &&
            (mFl[i][4] || mAsid[i] == lkAsid)) found = i;
      end
      if (found < 0) eMiss = 1;
      else begin
        bit need;
        logic [63:0] mask;
        need = (lkAccess == 2'd0) ? mFl[found][1] :
               (lkAccess == 2'd1) ? mFl[found][2] : mFl[found][3];
        if (mFl[found][0] && need) begin
          eHit = 1;
          mask = (64'd1 << shiftOf(mLvl[found])) - 64'd1;
          ePa  = ((mPpn[found] << 12) & ~mask) | (64'(lkVaddr) & mask);
        end else eFault = 1;
      end
    end
    vectors++;
    if (lkHit !== eHit || lkMiss !== eMiss || lkFault !== eFault || 64'(lkPaddr) !== ePa) begin
      errors++;
      $display("FAIL %s: hit/miss/fault/pa got %b%b%b %h expected %b%b%b %h",
               tag, lkHit, lkMiss, lkFault, lkPaddr, eHit, eMiss, eFault, ePa[55:0]);
    end
  endtask

  task automatic modelUpdate();
    if (!rstN) begin
      for (int i = 0; i < NE; i++) mUsed[i] = 0;
      mRr = 0;
    end else if (flushValid) begin
      for (int i = 0; i < NE; i++) begin
        if (mUsed[i] &&
            (!flushUseAddr || sameRegion(mVa[i], {25'd0, flushVpn, 12'd0}, mLvl[i])) &&
            (!flushUseAsid || (!mFl[i][4] && mAsid[i] == flushAsid)))
          mUsed[i] = 0;
      end
    end else if (fillValid) begin
      int slot = -1;
      for (int i = NE - 1; i >= 0; i--) if (!mUsed[i]) slot = i;
      if (slot < 0) begin
        slot = mRr;
        mRr = (mRr + 1) % NE;
      end
      mUsed[slot] = 1;
      mVa[slot]   = {25'd0, fillVpn, 12'd0};
      mAsid[slot] = fillAsid;
      mPpn[slot]  = 64'(fillPpn);
      mLvl[slot]  = (fillSize >= 2'd2) ? 2 : int'(fillSize);
      mFl[slot]   = fillFlags;
    end
  endtask

  task automatic tick(string tag);
    #1 checkNow(tag);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    clearInputs();
  endtask

  task automatic setLook(logic [38:0] va, logic [15:0] asid, logic [1:0] acc);
    lkValid = 1; lkVaddr = va; lkAsid = asid; lkAccess = acc;
  endtask

  task automatic look(logic [38:0] va, logic [15:0] asid, logic [1:0] acc, string tag);
    setLook(va, asid, acc);
    tick(tag);
  endtask

  task automatic setFill(logic [38:0] va, logic [15:0] asid, logic [43:0] ppn,
                         logic [1:0] sz, logic [4:0] fl);
    fillValid = 1; fillVpn = va[38:12]; fillAsid = asid; fillPpn = ppn;
    fillSize = sz; fillFlags = fl;
  endtask

  task automatic fill(logic [38:0] va, logic [15:0] asid, logic [43:0] ppn,
                      logic [1:0] sz, logic [4:0] fl, string tag);
    setFill(va, asid, ppn, sz, fl);
    tick(tag);
  endtask

  task automatic setFlush(bit useA, logic [38:0] va, bit useS, logic [15:0] asid);
    flushValid = 1; flushUseAddr = useA; flushVpn = va[38:12];
    flushUseAsid = useS; flushAsid = asid;
  endtask

  task automatic flush(bit useA, logic [38:0] va, bit useS, logic [15:0] asid, string tag);
    setFlush(useA, va, useS, asid);
    tick(tag);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finishRun();
  end

  initial begin
    logic [38:0] pA, pB, pC, pD;
    pA = mkVa(1, 2, 3, 0);
    pB = mkVa(1, 3, 0, 0);
    pC = mkVa(7, 0, 0, 0);
    pD = mkVa(2, 0, 0, 0);
    clearInputs();
    rstN = 0;
    @(negedge clk);
    setLook(pA, 16'd5, 2'd0);
    tick("R1");
    rstN = 1;
    // R1: empty after reset
    look(pA, 16'd5, 2'd0, "R1");
    tick("R3");

    // R12: fill not visible in its own cycle
    setFill(pA, 16'd5, 44'h12345, 2'd0, FL_V | FL_R | FL_W);
    setLook(pA | 39'h123, 16'd5, 2'd0);
    tick("R12");
    look(pA | 39'habc, 16'd5, 2'd0, "R2");
    look(pA | 39'h001, 16'd5, 2'd1, "R2");
    look(pA, 16'd5, 2'd2, "R7");
    look(mkVa(1, 2, 4, 0), 16'd5, 2'd0, "R4");
    look(pA, 16'd6, 2'd0, "R5");

    fill(pB, 16'd5, 44'h40000, 2'd1, FL_V | FL_R | FL_X, "R4");
    look(mkVa(1, 3, 77, 5), 16'd5, 2'd0, "R4");
    look(mkVa(1, 3, 511, 12'hfff), 16'd5, 2'd3, "R2");
    look(mkVa(1, 3, 9, 0), 16'd5, 2'd1, "R7");
    look(mkVa(1, 4, 0, 0), 16'd5, 2'd0, "R4");

    fill(pC, 16'd9, 44'h80000, 2'd2, FL_G | FL_V | FL_R | FL_W | FL_X, "R4");
    look(mkVa(7, 300, 12, 7), 16'd5, 2'd0, "R6");
    look(mkVa(7, 1, 2, 3), 16'd1, 2'd1, "R6");
    look(mkVa(8, 0, 0, 0), 16'd9, 2'd0, "R4");

    fill(pD, 16'd5, 44'h999, 2'd0, FL_R | FL_W | FL_X, "R7");
    look(pD, 16'd5, 2'd0, "R7");
    fill(pA, 16'd6, 44'h777, 2'd3 - 2'd3, FL_V | FL_R | FL_W, "R5");
    look(pA | 39'h44, 16'd6, 2'd0, "R5");
    look(pA | 39'h44, 16'd5, 2'd0, "R5");
    look(pA, 16'd7, 2'd0, "R5");

    // R10: ASID-only flush spares global and other ASIDs
    flush(0, '0, 1, 16'd5, "R10");
    look(pA, 16'd5, 2'd0, "R10");
    look(pB, 16'd5, 2'd0, "R10");
    look(pC, 16'd5, 2'd0, "R10");
    look(pA, 16'd6, 2'd0, "R10");

    // R9: address-only flush removes a global 1 GB entry
    flush(1, mkVa(7, 5, 5, 0), 0, '0, "R9");
    look(pC, 16'd9, 2'd0, "R9");

    fill(pA, 16'd5, 44'h12345, 2'd0, FL_V | FL_R | FL_W, "R11");
    fill(pB, 16'd5, 44'h40000, 2'd1, FL_V | FL_R | FL_X, "R11");
    flush(1, pA, 1, 16'd6, "R11");
    look(pA, 16'd5, 2'd0, "R11");
    look(pA, 16'd6, 2'd0, "R11");
    flush(1, mkVa(1, 3, 8, 0), 1, 16'd6, "R11");
    look(pB, 16'd5, 2'd0, "R11");
    flush(1, mkVa(1, 3, 8, 0), 1, 16'd5, "R11");
    look(pB, 16'd5, 2'd0, "R11");

    // R12: fill in the same cycle as a flush is dropped
    setFill(mkVa(3, 3, 3, 0), 16'd5, 44'h333, 2'd0, FL_V | FL_R);
    setFlush(0, '0, 1, 16'd99);
    tick("R12");
    look(mkVa(3, 3, 3, 0), 16'd5, 2'd0, "R12");

    // R8: flush everything
    flush(0, '0, 0, '0, "R8");
    look(pA, 16'd5, 2'd0, "R8");
    look(pD, 16'd5, 2'd0, "R8");

    // R13: fill order and round-robin replacement
    for (int k = 0; k < 8; k++)
      fill(mkVa(10, 0, k, 0), 16'd1, 44'(k + 1), 2'd0, FL_V | FL_R, "R13");
    for (int k = 0; k < 8; k++) look(mkVa(10, 0, k, 8), 16'd1, 2'd0, "R13");
    fill(mkVa(10, 0, 8, 0), 16'd1, 44'd9, 2'd0, FL_V | FL_R, "R13");
    fill(mkVa(10, 0, 9, 0), 16'd1, 44'd10, 2'd0, FL_V | FL_R, "R13");
    flush(1, mkVa(10, 0, 5, 0), 0, '0, "R13");
    fill(mkVa(10, 0, 10, 0), 16'd1, 44'd11, 2'd0, FL_V | FL_R, "R13");
    fill(mkVa(10, 0, 11, 0), 16'd1, 44'd12, 2'd0, FL_V | FL_R, "R13");
    for (int k = 0; k < 12; k++) look(mkVa(10, 0, k, 0), 16'd1, 2'd0, "R13");
    tick("R3");

    finishRun();
  end
endmodule